// File: doc/BRIEF.md
# Streaming 3x3 Gradient Convolver

The block takes a raster stream of 8-bit grayscale pixels straight from a camera front end and turns it into a horizontal and a vertical gradient for each pixel. Nothing is held as a full frame. Two line memories keep the two rows above the current one. A 3x3 register window slides along the current row. Each of the two kernels forms its nine coefficient products in one cycle. A registered adder tree then sums them. Different pixels sit in the multiply and add stages at the same time, so a dense input stream gives one gradient pair per clock.

The input is a pixel strobe with two markers: one for the start of the frame and one for the start of each line. The output is a strobe that carries both signed gradients and the column and row of the centre pixel. Each kernel's nine signed coefficients are writable one at a time. At reset they hold the Sobel pair. The default geometry is 320x240. It is a parameter, and the pixel rate is one per clock, so a clock well under 75 MHz keeps up with the frame rate.

Top module: `grad_conv3x3`

## Requirements
- R1: After reset, out_valid_o is 0, gx_o and gy_o are 0, and the coefficients hold the Sobel pair. Tap k=3*r+c, where r is the window row (0 = oldest) and c is the window column (0 = leftmost). x taps are {-1,0,1,-2,0,2,-1,0,1} and y taps are {-1,-2,-1,0,0,0,1,2,1}.
- R2: A pixel is taken only when pix_valid_i is 1. With sof_i it sits at column 0, row 0. With sol_i (and not sof_i) it sits at column 0 of the next row. Otherwise it sits at the next column. Idle cycles between pixels change nothing.
- R3: An accepted pixel at (col,row) with col>=1 and row>=1 emits exactly one output, for the centre (col-1,row-1). Outputs come in raster order. Centres in the last column or the last row are never emitted.
- R4: Each gradient is the sum over k of coef[k]*pixel[k]. Pixels are unsigned and coefficients are signed 4-bit.
- R5: A centre with x_o==0 or y_o==0 reports gx_o=0 and gy_o=0.
- R6: out_valid_o rises exactly 4 rising edges after the edge that accepts the completing pixel.
- R7: A write with coef_we_i=1 stores coef_val_i into tap coef_idx_i of kernel coef_sel_i (0 = x, 1 = y). It affects every window completed on the same edge or later. Writes with coef_idx_i>8 are ignored, and a write to one kernel leaves the other kernel unchanged.
- R8: Sums outside the 12-bit signed range saturate to 2047 or -2048.
- R9: Pixels accepted on back-to-back cycles produce outputs on back-to-back cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pix_valid_i | input | 1 | Pixel strobe |
| pix_i | input | 8 | Grayscale pixel |
| sof_i | input | 1 | First pixel of the frame |
| sol_i | input | 1 | First pixel of a line |
| coef_we_i | input | 1 | Coefficient write enable |
| coef_sel_i | input | 1 | Kernel select: 0 = x, 1 = y |
| coef_idx_i | input | 4 | Tap index, 0..8 |
| coef_val_i | input | 4 | Signed coefficient value |
| out_valid_o | output | 1 | Result strobe |
| gx_o | output | 12 | Signed horizontal gradient |
| gy_o | output | 12 | Signed vertical gradient |
| x_o | output | 9 | Centre column |
| y_o | output | 8 | Centre row |

## Verification
A coefficient write and the completion of a window can land on the same edge. In that case the product stage must already use the new value. The bench writes the x centre tap on the same cycle as it presents the pixel at column 3, row 2. It then compares every captured centre against a model. In that model, centres completed earlier in raster order use the old set, and that centre and all later ones use the new set. A single-cycle misalignment of the coefficient path makes the centre at (2,1) or its neighbour disagree with the model.

// File: rtl/grad_pkg.sv
package grad_pkg;
  localparam int unsigned TAPS = 9;

  typedef enum logic {KSEL_X = 1'b0, KSEL_Y = 1'b1} ksel_e;

  // Sobel reset value for tap k (k = 3*row + col)
  function automatic int sobel_tap(input logic ysel, input int k);
    int r, c;
    r = k / 3;
    c = k % 3;
    if (!ysel) return (c - 1) * ((r == 1) ? 2 : 1);
    else       return (r - 1) * ((c == 1) ? 2 : 1);
  endfunction
endpackage

// File: rtl/grad_coef_bank.sv
module grad_coef_bank
  import grad_pkg::*;
#(
  parameter int unsigned COEF_W = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     we_i,
  input  logic                     sel_i,
  input  logic [3:0]               idx_i,
  input  logic [COEF_W-1:0]        val_i,
  output logic [TAPS*COEF_W-1:0]   coef_x_o,
  output logic [TAPS*COEF_W-1:0]   coef_y_o
);
  logic [COEF_W-1:0] cx_q [TAPS];
  logic [COEF_W-1:0] cy_q [TAPS];
  logic              hit;

  assign hit = we_i && (int'(idx_i) < TAPS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < TAPS; k++) begin
        cx_q[k] <= COEF_W'(sobel_tap(1'b0, k));
        cy_q[k] <= COEF_W'(sobel_tap(1'b1, k));
      end
    end else if (hit) begin
      if (ksel_e'(sel_i) == KSEL_Y) cy_q[idx_i] <= val_i;
      else                          cx_q[idx_i] <= val_i;
    end
  end

  always_comb begin
    for (int k = 0; k < TAPS; k++) begin
      coef_x_o[k*COEF_W +: COEF_W] = cx_q[k];
      coef_y_o[k*COEF_W +: COEF_W] = cy_q[k];
    end
  end

  a_r7_ignore_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && idx_i > 4'd8) |=> ($stable(coef_x_o) && $stable(coef_y_o)));
  a_r7_x_keeps_y: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !sel_i) |=> $stable(coef_y_o));
  a_r7_y_keeps_x: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && sel_i) |=> $stable(coef_x_o));
endmodule

// File: rtl/grad_window.sv
module grad_window
  import grad_pkg::*;
#(
  parameter int unsigned PIX_W = 8,
  parameter int unsigned IMG_W = 320,
  parameter int unsigned IMG_H = 240,
  parameter int unsigned X_W   = $clog2(IMG_W),
  parameter int unsigned Y_W   = $clog2(IMG_H)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   pix_valid_i,
  input  logic [PIX_W-1:0]       pix_i,
  input  logic                   sof_i,
  input  logic                   sol_i,
  output logic [TAPS*PIX_W-1:0]  win_o,
  output logic                   win_valid_o,
  output logic                   win_border_o,
  output logic [X_W-1:0]         win_x_o,
  output logic [Y_W-1:0]         win_y_o
);
  logic [X_W-1:0]   col_q, col_d;
  logic [Y_W-1:0]   row_q, row_d;
  logic [PIX_W-1:0] lb0 [IMG_W];   // row above
  logic [PIX_W-1:0] lb1 [IMG_W];   // two rows above
  logic [PIX_W-1:0] win_q [3][3];  // [row][col], row 0 oldest
  logic [PIX_W-1:0] up1_px, up2_px;

  always_comb begin
    if (sof_i) begin
      col_d = '0;
      row_d = '0;
    end else if (sol_i) begin
      col_d = '0;
      row_d = row_q + 1'b1;
    end else begin
      col_d = col_q + 1'b1;
      row_d = row_q;
    end
  end

  assign up1_px = lb0[col_d];
  assign up2_px = lb1[col_d];

  always_ff @(posedge clk_i) begin
    if (pix_valid_i) begin
      lb1[col_d] <= up1_px;
      lb0[col_d] <= pix_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      col_q        <= '0;
      row_q        <= '0;
      win_valid_o  <= 1'b0;
      win_border_o <= 1'b0;
      win_x_o      <= '0;
      win_y_o      <= '0;
      for (int r = 0; r < 3; r++)
        for (int c = 0; c < 3; c++) win_q[r][c] <= '0;
    end else if (pix_valid_i) begin
      col_q <= col_d;
      row_q <= row_d;
      for (int r = 0; r < 3; r++) begin
        win_q[r][0] <= win_q[r][1];
        win_q[r][1] <= win_q[r][2];
      end
      win_q[0][2]  <= up2_px;
      win_q[1][2]  <= up1_px;
      win_q[2][2]  <= pix_i;
      win_valid_o  <= (col_d != '0) && (row_d != '0);
      win_border_o <= (col_d == X_W'(1)) || (row_d == Y_W'(1));
      win_x_o      <= col_d - 1'b1;
      win_y_o      <= row_d - 1'b1;
    end else begin
      win_valid_o <= 1'b0;
    end
  end

  always_comb begin
    for (int r = 0; r < 3; r++)
      for (int c = 0; c < 3; c++)
        win_o[(r*3+c)*PIX_W +: PIX_W] = win_q[r][c];
  end

  a_r2_idle_holds_position: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pix_valid_i |=> ($stable(col_q) && $stable(row_q)));
  a_r2_idle_no_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pix_valid_i |=> !win_valid_o);
endmodule

// File: rtl/grad_kernel.sv
module grad_kernel
  import grad_pkg::*;
#(
  parameter int unsigned PIX_W  = 8,
  parameter int unsigned COEF_W = 4,
  parameter int unsigned PROD_W = PIX_W + COEF_W + 1,
  parameter int unsigned SUM_W  = PROD_W + 4
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [TAPS*PIX_W-1:0]        win_i,
  input  logic [TAPS*COEF_W-1:0]       coef_i,
  output logic signed [SUM_W-1:0]      sum_o
);
  localparam int unsigned L1_N = (TAPS + 1) / 2;  // 5
  localparam int unsigned L2_N = (L1_N + 1) / 2;  // 3

  logic signed [PROD_W-1:0] pix_ext [TAPS];
  logic signed [PROD_W-1:0] coef_ext [TAPS];
  logic signed [PROD_W-1:0] prod_q [TAPS];
  logic signed [SUM_W-1:0]  s1_q [L1_N];
  logic signed [SUM_W-1:0]  s2_q [L2_N];
  logic                     prod_any;

  always_comb begin
    for (int k = 0; k < TAPS; k++) begin
      pix_ext[k]  = signed'(PROD_W'(win_i[k*PIX_W +: PIX_W]));
      coef_ext[k] = PROD_W'(signed'(coef_i[k*COEF_W +: COEF_W]));
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < TAPS; k++) prod_q[k] <= '0;
      for (int i = 0; i < L1_N; i++) s1_q[i] <= '0;
      for (int i = 0; i < L2_N; i++) s2_q[i] <= '0;
    end else begin
      for (int k = 0; k < TAPS; k++) prod_q[k] <= pix_ext[k] * coef_ext[k];
      for (int i = 0; i < L1_N; i++) begin
        if (2*i+1 < TAPS) s1_q[i] <= SUM_W'(prod_q[2*i]) + SUM_W'(prod_q[2*i+1]);
        else              s1_q[i] <= SUM_W'(prod_q[2*i]);
      end
      for (int i = 0; i < L2_N; i++) begin
        if (2*i+1 < L1_N) s2_q[i] <= s1_q[2*i] + s1_q[2*i+1];
        else              s2_q[i] <= s1_q[2*i];
      end
    end
  end

  always_comb begin
    sum_o = '0;
    for (int i = 0; i < L2_N; i++) sum_o = sum_o + s2_q[i];
  end

  always_comb begin
    prod_any = 1'b0;
    for (int k = 0; k < TAPS; k++) prod_any = prod_any | (prod_q[k] != '0);
  end

  a_r4_dark_window_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_i == '0) |=> !prod_any);
endmodule

// File: rtl/grad_conv3x3.sv
module grad_conv3x3
  import grad_pkg::*;
#(
  parameter int unsigned PIX_W  = 8,
  parameter int unsigned IMG_W  = 320,
  parameter int unsigned IMG_H  = 240,
  parameter int unsigned COEF_W = 4,
  parameter int unsigned OUT_W  = 12,
  parameter int unsigned X_W    = $clog2(IMG_W),
  parameter int unsigned Y_W    = $clog2(IMG_H)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     pix_valid_i,
  input  logic [PIX_W-1:0]         pix_i,
  input  logic                     sof_i,
  input  logic                     sol_i,
  input  logic                     coef_we_i,
  input  logic                     coef_sel_i,
  input  logic [3:0]               coef_idx_i,
  input  logic [COEF_W-1:0]        coef_val_i,
  output logic                     out_valid_o,
  output logic signed [OUT_W-1:0]  gx_o,
  output logic signed [OUT_W-1:0]  gy_o,
  output logic [X_W-1:0]           x_o,
  output logic [Y_W-1:0]           y_o
);
  localparam int unsigned PROD_W = PIX_W + COEF_W + 1;
  localparam int unsigned SUM_W  = PROD_W + 4;
  localparam int unsigned META_N = 3;  // products, L1, L2
  localparam logic signed [SUM_W-1:0] SAT_HI = SUM_W'((2**(OUT_W-1)) - 1);
  localparam logic signed [SUM_W-1:0] SAT_LO = -SAT_HI - 1;

  logic [TAPS*PIX_W-1:0]   win;
  logic                    win_valid, win_border;
  logic [X_W-1:0]          win_x;
  logic [Y_W-1:0]          win_y;
  logic [TAPS*COEF_W-1:0]  coef_x, coef_y;
  logic signed [SUM_W-1:0] sum_x, sum_y;

  logic           m_vld_q [META_N];
  logic           m_brd_q [META_N];
  logic [X_W-1:0] m_x_q   [META_N];
  logic [Y_W-1:0] m_y_q   [META_N];

  function automatic logic signed [OUT_W-1:0] sat(input logic signed [SUM_W-1:0] v);
    if (v > SAT_HI)      return SAT_HI[OUT_W-1:0];
    else if (v < SAT_LO) return SAT_LO[OUT_W-1:0];
    else                 return v[OUT_W-1:0];
  endfunction

  grad_window #(
    .PIX_W(PIX_W), .IMG_W(IMG_W), .IMG_H(IMG_H), .X_W(X_W), .Y_W(Y_W)
  ) u_win (
    .clk_i, .rst_ni, .pix_valid_i, .pix_i, .sof_i, .sol_i,
    .win_o(win), .win_valid_o(win_valid), .win_border_o(win_border),
    .win_x_o(win_x), .win_y_o(win_y)
  );

  grad_coef_bank #(.COEF_W(COEF_W)) u_coef (
    .clk_i, .rst_ni, .we_i(coef_we_i), .sel_i(coef_sel_i),
    .idx_i(coef_idx_i), .val_i(coef_val_i),
    .coef_x_o(coef_x), .coef_y_o(coef_y)
  );

  for (genvar g = 0; g < 2; g++) begin : g_kern
    logic signed [SUM_W-1:0] sum;
    grad_kernel #(
      .PIX_W(PIX_W), .COEF_W(COEF_W), .PROD_W(PROD_W), .SUM_W(SUM_W)
    ) u_kern (
      .clk_i, .rst_ni, .win_i(win),
      .coef_i((g == 0) ? coef_x : coef_y),
      .sum_o(sum)
    );
  end
  assign sum_x = g_kern[0].sum;
  assign sum_y = g_kern[1].sum;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < META_N; i++) begin
        m_vld_q[i] <= 1'b0;
        m_brd_q[i] <= 1'b0;
        m_x_q[i]   <= '0;
        m_y_q[i]   <= '0;
      end
      out_valid_o <= 1'b0;
      gx_o        <= '0;
      gy_o        <= '0;
      x_o         <= '0;
      y_o         <= '0;
    end else begin
      m_vld_q[0] <= win_valid;
      m_brd_q[0] <= win_border;
      m_x_q[0]   <= win_x;
      m_y_q[0]   <= win_y;
      for (int i = 1; i < META_N; i++) begin
        m_vld_q[i] <= m_vld_q[i-1];
        m_brd_q[i] <= m_brd_q[i-1];
        m_x_q[i]   <= m_x_q[i-1];
        m_y_q[i]   <= m_y_q[i-1];
      end
      out_valid_o <= m_vld_q[META_N-1];
      if (m_vld_q[META_N-1]) begin
        gx_o <= m_brd_q[META_N-1] ? '0 : sat(sum_x);
        gy_o <= m_brd_q[META_N-1] ? '0 : sat(sum_y);
        x_o  <= m_x_q[META_N-1];
        y_o  <= m_y_q[META_N-1];
      end
    end
  end

  a_r6_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> $past(win_valid, 4));
  a_r6_coord_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (x_o == $past(win_x, 4) && y_o == $past(win_y, 4)));
  a_r5_border_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && (x_o == '0 || y_o == '0)) |-> (gx_o == '0 && gy_o == '0));
endmodule

// File: tb/grad_conv3x3_test.sv
`timescale 1ns/1ps
module grad_conv3x3_test;
  localparam int W = 6;
  localparam int H = 5;
  localparam int XW = $clog2(W);
  localparam int YW = $clog2(H);
  localparam int CASES = 6;
  // {pattern kind, seed}
  localparam logic [11:0] CASE_TAB [CASES] = '{
    {4'd0, 8'd0}, {4'd1, 8'd0}, {4'd2, 8'd0},
    {4'd3, 8'd77}, {4'd4, 8'd200}, {4'd3, 8'd5}
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic pix_valid = 1'b0, sof = 1'b0, sol = 1'b0;
  logic [7:0] pix = '0;
  logic coef_we = 1'b0, coef_sel = 1'b0;
  logic [3:0] coef_idx = '0;
  logic [3:0] coef_val = '0;
  logic out_valid;
  logic signed [11:0] gx, gy;
  logic [XW-1:0] xo;
  logic [YW-1:0] yo;

  always #2 clk = ~clk;

  grad_conv3x3 #(.IMG_W(W), .IMG_H(H)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .pix_valid_i(pix_valid), .pix_i(pix),
    .sof_i(sof), .sol_i(sol), .coef_we_i(coef_we), .coef_sel_i(coef_sel),
    .coef_idx_i(coef_idx), .coef_val_i(coef_val), .out_valid_o(out_valid),
    .gx_o(gx), .gy_o(gy), .x_o(xo), .y_o(yo)
  );

  int nchk = 0, nbad = 0;
  int cyc = 0, seq = 0, acc_cyc = 0;
  int img [H][W];
  int cap_gx [H][W], cap_gy [H][W], cap_n [H][W], cap_seq [H][W], cap_cyc [H][W];
  int sob_x [9] = '{-1, 0, 1, -2, 0, 2, -1, 0, 1};
  int sob_y [9] = '{-1, -2, -1, 0, 0, 0, 1, 2, 1};
  int ctr_x [9] = '{0, 0, 0, 0, 1, 0, 0, 0, 0};
  int ctr2_x [9] = '{0, 0, 0, 0, 2, 0, 0, 0, 0};
  int max_x [9] = '{7, 7, 7, 7, 7, 7, 7, 7, 7};
  int min_y [9] = '{-8, -8, -8, -8, -8, -8, -8, -8, -8};

  always @(posedge clk) cyc++;

  always @(negedge clk) begin
    if (rst_ni && out_valid && int'(xo) < W && int'(yo) < H) begin
      cap_gx[yo][xo]  = gx;
      cap_gy[yo][xo]  = gy;
      cap_n[yo][xo]   = cap_n[yo][xo] + 1;
      cap_seq[yo][xo] = seq;
      cap_cyc[yo][xo] = cyc;
      seq++;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic int model(input int yc, input int xc, input int c[9]);
    int s = 0;
    if (xc == 0 || yc == 0) return 0;
    for (int r = 0; r < 3; r++)
      for (int q = 0; q < 3; q++)
        s += c[r*3+q] * img[yc-1+r][xc-1+q];
    if (s > 2047) s = 2047;
    if (s < -2048) s = -2048;
    return s;
  endfunction

  task automatic fill(input int kind, input int seed);
    int s = seed;
    for (int r = 0; r < H; r++)
      for (int c = 0; c < W; c++) begin
        case (kind)
          0: img[r][c] = c*40 + r*3;
          1: img[r][c] = r*50 + c*2;
          2: img[r][c] = ((r + c) % 2 == 1) ? 255 : 0;
          3: begin s = (s*109 + 89) % 256; img[r][c] = s; end
          default: img[r][c] = seed;
        endcase
      end
  endtask

  task automatic clear_cap();
    for (int r = 0; r < H; r++)
      for (int c = 0; c < W; c++) cap_n[r][c] = 0;
    seq = 0;
  endtask

  task automatic wr_coef(input bit sel, input int idx, input int val);
    @(negedge clk);
    coef_we = 1'b1; coef_sel = sel; coef_idx = 4'(idx); coef_val = 4'(val);
    @(negedge clk);
    coef_we = 1'b0;
  endtask

  // sw_idx: raster index of the pixel that shares its cycle with a coef write (-1: none)
  task automatic send_frame(input bit gap, input int sw_idx, input int sw_val);
    clear_cap();
    for (int r = 0; r < H; r++)
      for (int c = 0; c < W; c++) begin
        if (gap && c == 2) begin
          @(negedge clk);
          pix_valid = 1'b0; coef_we = 1'b0;
          pix = 8'hA5; sof = 1'b1; sol = 1'b1;  // noise while idle
        end
        @(negedge clk);
        pix_valid = 1'b1; pix = 8'(img[r][c]);
        sof = (r == 0 && c == 0); sol = (c == 0);
        coef_we = 1'b0;
        if (r*W + c == sw_idx) begin
          coef_we = 1'b1; coef_sel = 1'b0; coef_idx = 4'd4; coef_val = 4'(sw_val);
        end
        if (r == 1 && c == 1) acc_cyc = cyc + 1;
      end
    @(negedge clk);
    pix_valid = 1'b0; sof = 1'b0; sol = 1'b0; coef_we = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic verify(input int ax[9], input int ay[9], input int bx[9],
                        input int sw_idx, input bit dense, input string tag);
    int ex, ey;
    check(seq == (W-1)*(H-1), "R3", seq, (W-1)*(H-1));
    for (int y = 0; y < H; y++)
      for (int x = 0; x < W; x++) begin
        if (x == W-1 || y == H-1) begin
          check(cap_n[y][x] == 0, "R3", cap_n[y][x], 0);
        end else begin
          bit use_b = (sw_idx >= 0) && ((y+1)*W + (x+1) >= sw_idx);
          ex = use_b ? model(y, x, bx) : model(y, x, ax);
          ey = model(y, x, ay);
          check(cap_n[y][x] == 1, "R3", cap_n[y][x], 1);
          check(cap_seq[y][x] == y*(W-1) + x, "R3", cap_seq[y][x], y*(W-1) + x);
          if (x == 0 || y == 0) begin
            check(cap_gx[y][x] == 0 && cap_gy[y][x] == 0, "R5", cap_gx[y][x], 0);
          end else begin
            check(cap_gx[y][x] == ex, tag, cap_gx[y][x], ex);
            check(cap_gy[y][x] == ey, tag, cap_gy[y][x], ey);
          end
          if (dense && x > 0)
            check(cap_cyc[y][x] == cap_cyc[y][x-1] + 1, "R9",
                  cap_cyc[y][x] - cap_cyc[y][x-1], 1);
        end
      end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nbad++;
    $display("FAIL R3 watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset state
    check(out_valid == 1'b0, "R1", out_valid, 0);
    check(gx == 0 && gy == 0, "R1", gx, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    check(out_valid == 1'b0, "R1", out_valid, 0);

    // pattern table with reset coefficients (R1 Sobel, R4 sums, R2 with idle gaps)
    for (int i = 0; i < CASES; i++) begin
      bit gap = (i % 2 == 1);
      fill(int'(CASE_TAB[i][11:8]), int'(CASE_TAB[i][7:0]));
      send_frame(gap, -1, 0);
      verify(sob_x, sob_y, sob_x, -1, !gap, gap ? "R2" : (i == 0 ? "R1" : "R4"));
      if (i == 0)
        check(cap_cyc[0][0] - acc_cyc == 4, "R6", cap_cyc[0][0] - acc_cyc, 4);
    end

    // R7: load a centre-only x kernel, plus an out-of-range write that must be ignored
    for (int k = 0; k < 9; k++) wr_coef(1'b0, k, ctr_x[k]);
    wr_coef(1'b0, 12, 7);
    wr_coef(1'b1, 15, 7);
    fill(3, 31);
    send_frame(1'b0, -1, 0);
    verify(ctr_x, sob_y, ctr_x, -1, 1'b1, "R7");

    // R7: coefficient write on the same edge as the pixel at (3,2)
    fill(0, 0);
    send_frame(1'b0, 2*W + 3, 2);
    verify(ctr_x, sob_y, ctr2_x, 2*W + 3, 1'b1, "R7");

    // R8: saturation both ways
    for (int k = 0; k < 9; k++) wr_coef(1'b0, k, 7);
    for (int k = 0; k < 9; k++) wr_coef(1'b1, k, -8);
    fill(4, 255);
    send_frame(1'b0, -1, 0);
    verify(max_x, min_y, max_x, -1, 1'b1, "R8");
    check(cap_gx[2][2] == 2047, "R8", cap_gx[2][2], 2047);
    check(cap_gy[2][2] == -2048, "R8", cap_gy[2][2], -2048);

    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule